// File: doc/BRIEF.md
# Bunch-Crossing Trigger Pattern Decoder

This block watches one trigger line, chosen from three possible sources, and samples it once per bunch-crossing clock. The sampled bit stream carries short serial codes rather than plain pulses. A lone high sample is a physics trigger. Two or more adjacent highs are a calibration request. A high, one low, then another high is a reset command. The decoder turns each code into its own event, so calibration and reset codes never show up as triggers.

Each accepted trigger produces a one-cycle strobe and advances a wrapping trigger counter. Software can clear that counter synchronously. A free-running bunch-crossing counter advances every clock and returns to zero when a reset code is confirmed. A calibration code raises a one-cycle flag, which can be removed at build time through a parameter. Telling a lone pulse from the start of a longer code requires two samples of lookahead, so every decision comes out at a fixed delay after the first high sample.

Top module: `trig_pattern_filter`

## Requirements
- R1: `src_sel` picks the decoded line: 0 = `sw_trig`, 1 = `l1a_in`, 2 = `bp_trig`, 3 = no source (line held low). Activity on lines that are not selected has no effect on any output.
- R2: If the selected line is high at rising edge n, low at edges n-1, n+1 and n+2, and the decoder is idle, then `trig_stb` is high for exactly one cycle, between edges n+2 and n+3.
- R3: Pulses separated by two or more low samples are decoded independently, so the pattern 1001001 yields three triggers.
- R4: A run of two or more consecutive high samples beginning at edge n gives no trigger. With `CAL_FLAG_EN`=1 it raises `calib_seen` for one cycle, between edges n+1 and n+2, however long the run lasts. Decoding restarts after the first low sample that follows the run.
- R5: The pattern high-low-high, with its first high at edge n, gives no trigger and no calibration flag. `bx_count` reads 0 after edge n+3. High samples that directly follow the second high belong to the same command.
- R6: `bx_count` increases by one, modulo 2^`BX_W`, at every rising edge that does not clear it.
- R7: `trig_count` increases by one, modulo 2^`TRIG_W`, at the edge that ends each `trig_stb` cycle. A `cnt_clr` sampled high at an edge sets it to 0, and this takes priority over an increment at the same edge.
- R8: While `rst_n` is low, asynchronously, both counters are 0 and `trig_stb` and `calib_seen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Trigger source select |
| sw_trig | input | 1 | Software trigger line |
| l1a_in | input | 1 | Timing-system trigger line |
| bp_trig | input | 1 | Backplane trigger line |
| cnt_clr | input | 1 | Synchronous clear of the trigger counter |
| trig_stb | output | 1 | One-cycle accepted-trigger strobe |
| calib_seen | output | 1 | One-cycle calibration-request flag |
| trig_count | output | TRIG_W | Accepted-trigger count |
| bx_count | output | BX_W | Bunch-crossing count |

## Verification
The hardest cases are codes that run into one another: a reset code followed at once by more highs, a calibration run that ends one low sample before a new pulse, and a software clear that lands on the same edge as a trigger increment. To reach them, the stimulus feeds every 8-bit pattern through the decoder as one continuous stream. Each pattern is framed by low samples, and the source selection rotates from pattern to pattern. The unselected lines carry their own toggling activity throughout, and the counter clear fires at a fixed interval that is unrelated to the pattern framing. This lets every code boundary, source switch and clear collision occur somewhere in the stream.

// File: rtl/trig_pattern_filter.sv
module trig_pattern_filter #(
  parameter int TRIG_W      = 16,
  parameter int BX_W        = 12,
  parameter bit CAL_FLAG_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic              sw_trig,
  input  logic              l1a_in,
  input  logic              bp_trig,
  input  logic              cnt_clr,
  output logic              trig_stb,
  output logic              calib_seen,
  output logic [TRIG_W-1:0] trig_count,
  output logic [BX_W-1:0]   bx_count
);

  typedef enum logic [1:0] {S_IDLE, S_ONE, S_GAP, S_RUN} dec_t;

  logic sel_line, line_q, cal_det, rst_det;
  dec_t st, st_nx;

  always_comb begin
    case (src_sel)
      2'd0:    sel_line = sw_trig;
      2'd1:    sel_line = l1a_in;
      2'd2:    sel_line = bp_trig;
      default: sel_line = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= sel_line;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: if (line_q) st_nx = S_ONE;
      S_ONE:  st_nx = line_q ? S_RUN : S_GAP;
      S_GAP:  st_nx = line_q ? S_RUN : S_IDLE;
      S_RUN:  if (!line_q) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;

  assign trig_stb = (st == S_GAP) && !line_q;
  assign rst_det  = (st == S_GAP) &&  line_q;
  assign cal_det  = (st == S_ONE) &&  line_q;

  generate
    if (CAL_FLAG_EN) begin : g_cal
      assign calib_seen = cal_det;
    end else begin : g_nocal
      assign calib_seen = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        trig_count <= '0;
    else if (cnt_clr)  trig_count <= '0;
    else if (trig_stb) trig_count <= trig_count + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bx_count <= '0;
    else if (rst_det) bx_count <= '0;
    else              bx_count <= bx_count + 1'b1;

  p_no_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3) |=> !line_q);

  p_trig_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_stb |-> (!line_q && !$past(line_q) && $past(line_q, 2) && !$past(line_q, 3)));

  p_one_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trig_stb, rst_det, cal_det}));

  p_cal_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_det |-> (line_q && $past(line_q) && !$past(cal_det)));

  p_bx_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_det |=> (bx_count == '0));

  p_bx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_det |=> (bx_count == BX_W'($past(bx_count) + 1'b1)));

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_stb && !cnt_clr) |=> (trig_count == TRIG_W'($past(trig_count) + 1'b1)));

  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (trig_count == '0));

  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_stb && !cnt_clr) |=> $stable(trig_count));

endmodule

// File: tb/trig_pattern_filter_test.sv
module trig_pattern_filter_test;
  localparam int TW = 8, BW = 6, NPAT = 256, BLK = 11, N = NPAT * BLK + 8;
  localparam int TM = (1 << TW) - 1, BM = (1 << BW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sw_trig, l1a_in, bp_trig, cnt_clr, trig_stb, calib_seen;
  logic [1:0] src_sel;
  logic [TW-1:0] trig_count;
  logic [BW-1:0] bx_count;

  trig_pattern_filter #(.TRIG_W(TW), .BX_W(BW), .CAL_FLAG_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sw_trig(sw_trig),
    .l1a_in(l1a_in), .bp_trig(bp_trig), .cnt_clr(cnt_clr),
    .trig_stb(trig_stb), .calib_seen(calib_seen),
    .trig_count(trig_count), .bx_count(bx_count));

  bit xs[N];
  bit y[N+3];
  bit clr_a[N];
  logic [1:0] sel_a[N];
  bit etrig[N+3], ecal[N+3], erst[N+3];
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(int n);
    bit j;
    j = bit'(((n * 5) >> 1) ^ (n >> 3));
    src_sel = sel_a[n];
    sw_trig = (sel_a[n] == 2'd0) ? xs[n] : j;
    l1a_in  = (sel_a[n] == 2'd1) ? xs[n] : ~j;
    bp_trig = (sel_a[n] == 2'd2) ? xs[n] : j;
    cnt_clr = clr_a[n];
  endtask

  task automatic finish_up();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
    end
  end

  initial begin
    int bxp, cp, i;
    for (int n = 0; n < N; n++) begin
      int p, off;
      p = n / BLK;
      off = n % BLK;
      xs[n] = (p < NPAT && off >= 3) ? bit'((p >> (off - 3)) & 1) : 1'b0;
      sel_a[n] = (p < NPAT) ? 2'(p % 4) : 2'd0;
      clr_a[n] = (n % 97 == 50);
    end
    for (int n = 0; n < N + 3; n++) begin
      y[n] = (n < N && sel_a[n] != 2'd3) ? xs[n] : 1'b0;
      etrig[n] = 1'b0; ecal[n] = 1'b0; erst[n] = 1'b0;
    end
    i = 0;
    while (i < N) begin
      if (y[i]) begin
        if (y[i+1]) begin
          ecal[i+1] = 1'b1;
          i = i + 1;
          while (i < N + 3 && y[i]) i++;
        end else if (y[i+2]) begin
          erst[i+2] = 1'b1;
          i = i + 2;
          while (i < N + 3 && y[i]) i++;
        end else begin
          etrig[i+2] = 1'b1;
          i = i + 3;
        end
      end else i++;
    end

    rst_n = 1'b0;
    src_sel = 2'd0; sw_trig = 1'b1; l1a_in = 1'b1; bp_trig = 1'b1; cnt_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset bx_count", int'(bx_count), 0);
    chk("R8 reset trig_count", int'(trig_count), 0);
    chk("R8 reset trig_stb", int'(trig_stb), 0);
    chk("R8 reset calib_seen", int'(calib_seen), 0);
    sw_trig = 1'b0; l1a_in = 1'b0; bp_trig = 1'b0;
    rst_n = 1'b1;
    drive(0);
    bxp = 0;
    cp = 0;
    for (int n = 0; n < N; n++) begin
      int eb, ec;
      @(posedge clk);
      @(negedge clk);
      eb = (n > 0 && erst[n-1]) ? 0 : ((bxp + 1) & BM);
      ec = clr_a[n] ? 0 : ((cp + ((n > 0 && etrig[n-1]) ? 1 : 0)) & TM);
      chk("R1 R2 R3 trig_stb", int'(trig_stb), int'(etrig[n]));
      chk("R1 R4 calib_seen", int'(calib_seen), int'(ecal[n]));
      chk("R5 R6 bx_count", int'(bx_count), eb);
      chk("R7 trig_count", int'(trig_count), ec);
      bxp = eb;
      cp = ec;
      if (n + 1 < N) drive(n + 1);
    end

    @(posedge clk);
    #3 rst_n = 1'b0;
    #1;
    chk("R8 async trig_count", int'(trig_count), 0);
    chk("R8 async bx_count", int'(bx_count), 0);
    chk("R8 async trig_stb", int'(trig_stb), 0);
    finish_up();
  end
endmodule